// File: doc/BRIEF.md
# Valley Lockout Selector with Hysteresis

This block chooses which resonant valley, from the first to the sixth, a quasi-resonant converter switches on in. It takes an 8-bit output-current setpoint code, where 255 is full reference, and two line comparator flags: one says the line is above the high threshold and the other says it is below the low threshold. From these it produces a valley index and a frequency-foldback flag. The valley index is locked in place. It moves only when the setpoint crosses one of two separate thresholds, one for falling and one for rising, so small setpoint ripple does not make it bounce between valleys.

The line range moves the whole valley ladder up by one. The setpoint band gives valley 1 to 5 at low line and valley 2 to 6 at high line. A tick input, nominally 1 ms, times the blanking that a new line range must survive before it is accepted. Below the lowest ladder step the block enters foldback mode. In that mode the ladder position is frozen and only the foldback flag is raised for the dead-time logic downstream.

Top module: `valley_lock`

## Requirements
- R1: While reset is asserted, the block outputs valley 1 with foldback clear and low line. On the first clock after reset, the band is loaded without hysteresis. The band equals the number of falling codes {204,165,127,89} that the setpoint is below, and foldback is set if the setpoint is below 63.
- R2: When not in foldback, a setpoint below the falling code of the current band (204, 165, 127 and 89 for bands 0 to 3) raises the band by exactly one on the next clock. The band moves at most one step per clock and never goes above 4.
- R3: When not in foldback, a setpoint above the rising code of the band one below (216, 178, 140 and 102 for bands 1 to 4) lowers the band by exactly one on the next clock.
- R4: A setpoint that lies between the falling code of the current band and the rising code of the band below leaves the band unchanged.
- R5: The valley output equals band+1 at low line and band+2 at high line.
- R6: The raw line range is set by the above-high flag and cleared by the below-low flag. With neither flag it keeps its value. If both flags are asserted, high line wins.
- R7: The committed line range takes the raw value only after the raw value has differed from it for 25 consecutive ticks. The committed range changes only on a clock where tick is high. If the raw value returns to the committed value before then, the count restarts.
- R8: Foldback is set when the setpoint is below 63 and cleared when it is above 76. While foldback is set, the band is frozen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| setpoint | input | 8 | Output-current setpoint code, 255 = full reference |
| lineAboveHigh | input | 1 | Line above high-range threshold |
| lineBelowLow | input | 1 | Line below low-range threshold |
| tick | input | 1 | Blanking time base strobe |
| valley | output | 3 | Selected valley index, 1 to 6 |
| foldback | output | 1 | Frequency-foldback mode active |

## Verification
The hardest case to reach is a line range that reverses partway through the blanking window, because it only shows up if the change is abandoned after a count of ticks has built up. The stimulus pulses the below-low flag, lets about ten ticks pass, and then pulses both flags together. It then checks that the valley never moves. A second hard case is a setpoint that drops to zero in one step: the foldback flag and the first ladder step land on the same clock, and the band must then stay frozen. A behavioural model driven by a pseudo-random sweep of setpoints and line flags covers the mixed cases.

// File: rtl/vlk_pkg.sv
package vlk_pkg;
  typedef struct packed {
    logic loadInit;
    logic stepDown;
    logic stepUp;
    logic fbSet;
    logic fbClr;
  } vlkStrobes_t;

  function automatic int pctToCode(input int pct, input int fullCode);
    return (pct * fullCode) / 100;
  endfunction
endpackage

// File: rtl/vlk_datapath.sv
module vlk_datapath
  import vlk_pkg::*;
#(
  parameter int SP_W         = 8,
  parameter int NUM_STEPS    = 4,
  parameter int FALL_TOP_PCT = 80,
  parameter int STEP_PCT     = 15,
  parameter int HYST_PCT     = 5,
  parameter int FB_ENTER_PCT = 25,
  parameter int FB_EXIT_PCT  = 30,
  localparam int BAND_W      = $clog2(NUM_STEPS + 1),
  localparam int VAL_W       = $clog2(NUM_STEPS + 3)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SP_W-1:0]   setpoint,
  input  vlkStrobes_t       str,
  input  logic              highLine,
  output logic              cmpDown,
  output logic              cmpUp,
  output logic              fbLow,
  output logic              fbHigh,
  output logic              fbOn,
  output logic [VAL_W-1:0]  valley
);
  localparam int FULL_CODE    = (1 << SP_W) - 1;
  localparam int FB_ENTER_CODE = pctToCode(FB_ENTER_PCT, FULL_CODE);
  localparam int FB_EXIT_CODE  = pctToCode(FB_EXIT_PCT, FULL_CODE);

  logic [NUM_STEPS:0] belowFall;
  logic [NUM_STEPS:0] aboveRise;
  logic [BAND_W-1:0]  band;
  logic [BAND_W-1:0]  initBand;

  assign belowFall[NUM_STEPS] = 1'b0;
  assign aboveRise[0]         = 1'b0;

  for (genvar k = 0; k < NUM_STEPS; k++) begin : g_thr
    localparam int FALL_CODE = pctToCode(FALL_TOP_PCT - k * STEP_PCT, FULL_CODE);
    localparam int RISE_CODE = pctToCode(FALL_TOP_PCT - k * STEP_PCT + HYST_PCT, FULL_CODE);
    assign belowFall[k]   = (setpoint < SP_W'(FALL_CODE));
    assign aboveRise[k+1] = (setpoint > SP_W'(RISE_CODE));
  end

  always_comb begin
    initBand = '0;
    for (int k = 0; k < NUM_STEPS; k++) begin
      initBand = initBand + BAND_W'(belowFall[k]);
    end
  end

  assign cmpDown = belowFall[band];
  assign cmpUp   = aboveRise[band];
  assign fbLow   = (setpoint < SP_W'(FB_ENTER_CODE));
  assign fbHigh  = (setpoint > SP_W'(FB_EXIT_CODE));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      band <= '0;
      fbOn <= 1'b0;
    end else begin
      if (str.loadInit)      band <= initBand;
      else if (str.stepDown) band <= band + BAND_W'(1);
      else if (str.stepUp)   band <= band - BAND_W'(1);

      if (str.loadInit)   fbOn <= fbLow;
      else if (str.fbSet) fbOn <= 1'b1;
      else if (str.fbClr) fbOn <= 1'b0;
    end
  end

  assign valley = VAL_W'(band) + VAL_W'(1) + VAL_W'(highLine);

  assert_band_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !str.loadInit |=> (band == $past(band)) || (band == $past(band) + BAND_W'(1))
                      || (band + BAND_W'(1) == $past(band)));

  assert_fb_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fbOn |=> $stable(band));

  assert_fb_entry_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fbOn) |-> ($past(setpoint) < SP_W'(FB_ENTER_CODE)));

  assert_valley_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (valley >= VAL_W'(1)) && (valley <= VAL_W'(NUM_STEPS + 2)));
endmodule

// File: rtl/vlk_control.sv
module vlk_control
  import vlk_pkg::*;
#(
  parameter int BLANK_TICKS = 25,
  localparam int CNT_W      = $clog2(BLANK_TICKS + 1)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        lineAboveHigh,
  input  logic        lineBelowLow,
  input  logic        tick,
  input  logic        cmpDown,
  input  logic        cmpUp,
  input  logic        fbLow,
  input  logic        fbHigh,
  input  logic        fbOn,
  output vlkStrobes_t str,
  output logic        highLine
);
  logic             initPending;
  logic             rawHigh;
  logic [CNT_W-1:0] blankCnt;

  always_comb begin
    str          = '0;
    str.loadInit = initPending;
    if (!initPending) begin
      str.stepDown = !fbOn && cmpDown;
      str.stepUp   = !fbOn && !cmpDown && cmpUp;
      str.fbSet    = !fbOn && fbLow;
      str.fbClr    = fbOn && fbHigh;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      initPending <= 1'b1;
      rawHigh     <= 1'b0;
      highLine    <= 1'b0;
      blankCnt    <= '0;
    end else begin
      initPending <= 1'b0;
      if (lineAboveHigh)     rawHigh <= 1'b1;
      else if (lineBelowLow) rawHigh <= 1'b0;

      if (rawHigh == highLine) begin
        blankCnt <= '0;
      end else if (tick) begin
        if (blankCnt == CNT_W'(BLANK_TICKS - 1)) begin
          highLine <= rawHigh;
          blankCnt <= '0;
        end else begin
          blankCnt <= blankCnt + CNT_W'(1);
        end
      end
    end
  end

  assert_line_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(highLine));

  assert_line_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (highLine != $past(highLine)) |-> (highLine == $past(rawHigh)));

  assert_step_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({str.stepDown, str.stepUp, str.loadInit}));
endmodule

// File: rtl/valley_lock.sv
module valley_lock
  import vlk_pkg::*;
#(
  parameter int SP_W         = 8,
  parameter int NUM_STEPS    = 4,
  parameter int FALL_TOP_PCT = 80,
  parameter int STEP_PCT     = 15,
  parameter int HYST_PCT     = 5,
  parameter int FB_ENTER_PCT = 25,
  parameter int FB_EXIT_PCT  = 30,
  parameter int BLANK_TICKS  = 25,
  localparam int VAL_W       = $clog2(NUM_STEPS + 3)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SP_W-1:0]  setpoint,
  input  logic             lineAboveHigh,
  input  logic             lineBelowLow,
  input  logic             tick,
  output logic [VAL_W-1:0] valley,
  output logic             foldback
);
  vlkStrobes_t str;
  logic highLine, cmpDown, cmpUp, fbLow, fbHigh, fbOn;

  vlk_control #(.BLANK_TICKS(BLANK_TICKS)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .lineAboveHigh(lineAboveHigh), .lineBelowLow(lineBelowLow), .tick(tick),
    .cmpDown(cmpDown), .cmpUp(cmpUp), .fbLow(fbLow), .fbHigh(fbHigh), .fbOn(fbOn),
    .str(str), .highLine(highLine)
  );

  vlk_datapath #(
    .SP_W(SP_W), .NUM_STEPS(NUM_STEPS), .FALL_TOP_PCT(FALL_TOP_PCT),
    .STEP_PCT(STEP_PCT), .HYST_PCT(HYST_PCT),
    .FB_ENTER_PCT(FB_ENTER_PCT), .FB_EXIT_PCT(FB_EXIT_PCT)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .setpoint(setpoint), .str(str), .highLine(highLine),
    .cmpDown(cmpDown), .cmpUp(cmpUp), .fbLow(fbLow), .fbHigh(fbHigh),
    .fbOn(fbOn), .valley(valley)
  );

  assign foldback = fbOn;
endmodule

// File: tb/sim_valley_lock.sv
module sim_valley_lock;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] setpoint = 8'd100;
  logic       lineAboveHigh = 1'b0;
  logic       lineBelowLow = 1'b0;
  logic       tick = 1'b0;
  logic [2:0] valley;
  logic       foldback;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  string phase = "R1";

  always #2 clk = ~clk;

  valley_lock u0 (
    .clk(clk), .rst_n(rst_n), .setpoint(setpoint),
    .lineAboveHigh(lineAboveHigh), .lineBelowLow(lineBelowLow), .tick(tick),
    .valley(valley), .foldback(foldback)
  );

  // behavioural reference
  int fallC[4] = '{204, 165, 127, 89};
  int riseC[4] = '{216, 178, 140, 102};
  int mBand, mFb, mInit, mRaw, mHigh, mCnt;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mBand = 0; mFb = 0; mInit = 1; mRaw = 0; mHigh = 0; mCnt = 0;
    end else begin
      int sp, nb, nf, nr;
      sp = setpoint;
      nb = mBand; nf = mFb;
      if (mInit == 1) begin
        nb = 0;
        foreach (fallC[i]) if (sp < fallC[i]) nb++;
        nf = (sp < 63) ? 1 : 0;
      end else if (mFb == 0) begin
        if (mBand < 4 && sp < fallC[mBand]) nb = mBand + 1;
        else if (mBand > 0 && sp > riseC[mBand-1]) nb = mBand - 1;
        if (sp < 63) nf = 1;
      end else if (sp > 76) nf = 0;
      nr = lineAboveHigh ? 1 : (lineBelowLow ? 0 : mRaw);
      if (mRaw == mHigh) mCnt = 0;
      else if (tick) begin
        if (mCnt == 24) begin mHigh = mRaw; mCnt = 0; end
        else mCnt++;
      end
      mBand = nb; mFb = nf; mInit = 0; mRaw = nr;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (valley !== 3'(mBand + 1 + mHigh) || foldback !== 1'(mFb)) begin
        fails++;
        $display("FAIL %s model: valley=%0d fb=%0d expected valley=%0d fb=%0d",
                 phase, valley, foldback, mBand + 1 + mHigh, mFb);
      end
    end
  end

  initial forever begin
    repeat (3) @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  end

  task automatic expect_out(input string req, input int expV, input int expF);
    checks++;
    if (valley !== 3'(expV) || foldback !== 1'(expF)) begin
      fails++;
      $display("FAIL %s: valley=%0d fb=%0d expected valley=%0d fb=%0d",
               req, valley, foldback, expV, expF);
    end
  endtask

  task automatic hold(input int sp, input int n);
    @(negedge clk);
    setpoint = 8'(sp);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input bit hi, input bit lo);
    @(negedge clk);
    lineAboveHigh = hi; lineBelowLow = lo;
    @(negedge clk);
    lineAboveHigh = 0; lineBelowLow = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(4 * 100000);
    fails++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    phase = "R1";
    expect_out("R1 reset", 1, 0);
    rst_n = 1'b1;
    @(negedge clk);
    expect_out("R1 init band", 4, 0);

    phase = "R3";
    hold(255, 6);  expect_out("R3 full scale", 1, 0);
    phase = "R4";
    hold(205, 4);  expect_out("R4 above fall", 1, 0);
    phase = "R2";
    hold(203, 3);  expect_out("R2 below fall", 2, 0);
    phase = "R4";
    hold(210, 3);  expect_out("R4 hysteresis", 2, 0);
    phase = "R3";
    hold(217, 3);  expect_out("R3 above rise", 1, 0);
    phase = "R8";
    hold(0, 5);    expect_out("R8 fb frozen", 2, 1);
    hold(70, 5);   expect_out("R8 fb hold", 2, 1);
    hold(77, 6);   expect_out("R2 fb exit steps", 5, 0);

    phase = "R7";
    pulse(1, 0);
    repeat (60) @(negedge clk);
    expect_out("R7 blanking", 5, 0);
    repeat (60) @(negedge clk);
    phase = "R5";
    expect_out("R5 high line", 6, 0);
    phase = "R7";
    pulse(0, 1);
    repeat (40) @(negedge clk);
    phase = "R6";
    pulse(1, 1);
    repeat (120) @(negedge clk);
    expect_out("R6 R7 abort", 6, 0);
    pulse(0, 1);
    repeat (120) @(negedge clk);
    expect_out("R7 back low", 5, 0);

    phase = "R1";
    @(negedge clk);
    setpoint = 8'd50;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    expect_out("R1 init fb", 5, 1);

    phase = "R2 R3 R5 R6 R8 sweep";
    begin
      logic [15:0] lfsr = 16'hACE1;
      for (int i = 0; i < 3000; i++) begin
        @(negedge clk);
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        if (i % 3 == 0) setpoint = lfsr[7:0];
        lineAboveHigh = (lfsr[15:11] == 5'd0);
        lineBelowLow  = (lfsr[10:6] == 5'd0);
      end
    end
    @(negedge clk);
    finish_run();
  end
endmodule